// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame should be kept, judging only by its 48-bit destination address. For a group address (bit 0 of the first received byte set), it runs a CRC-32 over the six address bytes and reverses the bits of the result. The top eight bits of the reversed value then pick one of 256 entries in a hash table held in eight 32-bit configuration registers, and the frame is kept when that entry is set. For an individual address, the block compares the whole address with a programmed station address. A promiscuous bit in a control register overrides both tests and keeps every frame.

The address arrives in one of two ways. It can come as a stream of six bytes, with the first byte marked, and gaps are allowed between bytes. It can also come as one 48-bit word in a single cycle. Each decision appears as a one-cycle pulse on `dec_valid`, together with the accept flag, the group flag and the hash index that was used. A byte-stream frame is judged with the configuration that was in place when its first byte arrived. A later write therefore changes only the frames that start after it.

Top module: `mhf_filter`

## Requirements
- R1: The hash is the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, no final complement). Bytes are fed in order of arrival and each byte least significant bit first. `dec_index` bit 7 equals CRC bit 0, bit 6 equals CRC bit 1, and so on down to bit 0, which equals CRC bit 7. `dec_index` is reported with every decision.
- R2: Table register k (write address k, 0 to 7) holds entries 32k to 32k+31. Entry 32k+j sits at bit 31-j of that register. With promiscuous mode off, a group frame is accepted exactly when the entry at its index is 1.
- R3: After reset, all table registers, the station address and the promiscuous bit are zero, and `dec_valid` and `dec_accept` are low. No group frame is accepted until the table is written.
- R4: `dec_group` reports bit 0 of the first received address byte. In the word form this is `word_da[40]`, since `word_da[47:40]` is the first byte.
- R5: An individual frame is accepted when all 48 address bits equal the station address. Write address 8 holds byte 5 in bits 31:24, byte 4 in bits 23:16, byte 3 in bits 15:8 and byte 2 in bits 7:0. Write address 9 holds byte 1 in bits 31:24 and byte 0 in bits 23:16, and its bits 15:0 are ignored. Byte 0 is the first received byte.
- R6: Bit 0 of write address 10 is the promiscuous bit. While it is 1, every frame is accepted.
- R7: A byte frame opens with a byte that has `byte_first` set. `dec_valid` pulses for one cycle in the cycle after the clock edge that takes the sixth byte. It stays low while the frame is being collected.
- R8: A word presented with `word_valid` is decided in the following cycle.
- R9: Bytes without `byte_first` are ignored when no frame is open, including any bytes after the sixth. A `byte_first` byte in the middle of a frame discards that frame and starts a new one.
- R10: A byte frame uses the configuration as it stood before the edge that takes its first byte. A write at or after that edge affects only later frames.
- R11: When `word_valid` and `byte_valid` are high in the same cycle, the word is decided, the byte is dropped, and any open byte frame is abandoned.
- R12: Writes to addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 4 | Configuration register address |
| cfg_wr_data | input | 32 | Configuration write data |
| byte_valid | input | 1 | Address byte present |
| byte_first | input | 1 | Byte is the first of an address |
| byte_data | input | 8 | Address byte |
| word_valid | input | 1 | Whole address present |
| word_da | input | 48 | Whole address, first byte in bits 47:40 |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_group | output | 1 | Address was a group address |
| dec_index | output | 8 | Hash index used for the decision |

## Verification
A corrupted CRC state or a byte shifted into the wrong place shows up as a wrong `dec_index`, and often a wrong accept flag, in the decision pulse of that same frame, one cycle after its sixth byte. A byte counter that drifts shows up as a `dec_valid` pulse that comes early, late or not at all. That error is visible within one frame, and trailing or unmarked bytes expose it. A snapshot that is refreshed at the wrong moment flips the accept flag of a frame that is being collected while a table write lands. A wrong mapping from index to register bit rejects a frame whose single programmed entry is the only bit set in the table.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   // Reflected CRC-32 constants used by the hash.
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

   // Destination address geometry.
   localparam int unsigned DA_BYTES = 6;
   localparam int unsigned DA_BITS  = DA_BYTES * 8;

   // State of the byte-stream collector.
   typedef enum logic [0:0] {
      RX_CLOSED = 1'b0,
      RX_OPEN   = 1'b1
   } rx_state_e;

endpackage

// File: rtl/mhf_crc_byte.sv
// One byte of the reflected CRC-32, taken least significant bit first.
module mhf_crc_byte
   import mhf_pkg::*;
(
   input  logic [31:0] crc_in,
   input  logic [7:0]  data_in,
   output logic [31:0] crc_out
);

   logic [31:0] acc;

   always_comb begin
      acc = crc_in;
      for (int b = 0; b < 8; b++) begin
         if (acc[0] ^ data_in[b]) begin
            acc = (acc >> 1) ^ CRC_POLY_REFL;
         end else begin
            acc = acc >> 1;
         end
      end
      crc_out = acc;
   end

endmodule

// File: rtl/mhf_cfg_regs.sv
// Write-only configuration: hash table words, station address and control bit.
module mhf_cfg_regs #(
   parameter  int unsigned TABLE_REGS = 8,
   parameter  int unsigned REG_W      = 32,
   parameter  int unsigned REG_AW     = 4,
   localparam int unsigned TBL_BITS   = TABLE_REGS * REG_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_AW-1:0]   wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   output logic [TBL_BITS-1:0] table_o,
   output logic [47:0]         station_o,
   output logic                promisc_o
);

   localparam logic [REG_AW-1:0] STN_A_ADDR = REG_AW'(TABLE_REGS);
   localparam logic [REG_AW-1:0] STN_B_ADDR = REG_AW'(TABLE_REGS + 1);
   localparam logic [REG_AW-1:0] CTRL_ADDR  = REG_AW'(TABLE_REGS + 2);

   if (REG_W != 32) begin : g_bad_reg_w
      $error("mhf_cfg_regs: REG_W must be 32");
   end
   if ((1 << REG_AW) < TABLE_REGS + 3) begin : g_bad_aw
      $error("mhf_cfg_regs: REG_AW too narrow for the register map");
   end

   // Hash table words, one generate block per register.
   for (genvar k = 0; k < TABLE_REGS; k++) begin : g_tbl
      logic [REG_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && wr_addr == REG_AW'(k)) begin
            word_q <= wr_data;
         end
      end
      assign table_o[k*REG_W +: REG_W] = word_q;
   end

   logic [31:0] stn_a_q;   // bytes 5..2
   logic [15:0] stn_b_q;   // bytes 1..0
   logic        prm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stn_a_q <= '0;
         stn_b_q <= '0;
         prm_q   <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == STN_A_ADDR) stn_a_q <= wr_data[31:0];
         if (wr_addr == STN_B_ADDR) stn_b_q <= wr_data[31:16];
         if (wr_addr == CTRL_ADDR)  prm_q   <= wr_data[0];
      end
   end

   // Reassemble into arrival order: byte 0 in bits 47:40.
   assign station_o = {stn_b_q[7:0], stn_b_q[15:8],
                       stn_a_q[7:0], stn_a_q[15:8], stn_a_q[23:16], stn_a_q[31:24]};
   assign promisc_o = prm_q;

   // R6: a control write sets the promiscuous bit seen on the next cycle.
   a_r6_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_ADDR) |=> (promisc_o == $past(wr_data[0])));

   // R12: writes above the control address leave all state untouched.
   a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > CTRL_ADDR) |=>
         ($stable(table_o) && $stable(station_o) && $stable(promisc_o)));

endmodule

// File: rtl/mhf_lookup.sv
// Index extraction, table bit selection and the accept decision.
module mhf_lookup
   import mhf_pkg::*;
#(
   parameter  int unsigned TABLE_REGS = 8,
   parameter  int unsigned REG_W      = 32,
   localparam int unsigned TBL_BITS   = TABLE_REGS * REG_W,
   localparam int unsigned IDX_W      = $clog2(TBL_BITS),
   localparam int unsigned BIT_W      = $clog2(REG_W)
)(
   input  logic [IDX_W-1:0]    crc_lo,
   input  logic [DA_BITS-1:0]  da,
   input  logic [TBL_BITS-1:0] table_bits,
   input  logic [47:0]         station,
   input  logic                promisc,
   output logic [IDX_W-1:0]    index_o,
   output logic                group_o,
   output logic                accept_o
);

   if (TABLE_REGS < 2 || (TBL_BITS & (TBL_BITS - 1)) != 0) begin : g_bad_size
      $error("mhf_lookup: table must be a power of two with at least two words");
   end
   if (IDX_W > 32) begin : g_bad_idx
      $error("mhf_lookup: index wider than the CRC");
   end

   // Top bits of the bit-reversed CRC are the low CRC bits in reverse order.
   for (genvar i = 0; i < IDX_W; i++) begin : g_rev
      assign index_o[IDX_W-1-i] = crc_lo[i];
   end

   // Upper index bits select the word; the low field counts from the word's MSB.
   logic [IDX_W-1:0] tbl_pos;
   logic             hit;

   assign tbl_pos  = {index_o[IDX_W-1:BIT_W], ~index_o[BIT_W-1:0]};
   assign hit      = table_bits[tbl_pos];
   assign group_o  = da[DA_BITS-8];
   assign accept_o = promisc | (group_o ? hit : (da == station));

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
   import mhf_pkg::*;
#(
   parameter  int unsigned TABLE_REGS = 8,
   parameter  int unsigned REG_W      = 32,
   parameter  int unsigned REG_AW     = 4,
   localparam int unsigned IDX_W      = $clog2(TABLE_REGS * REG_W)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [REG_AW-1:0]  cfg_wr_addr,
   input  logic [REG_W-1:0]   cfg_wr_data,
   input  logic               byte_valid,
   input  logic               byte_first,
   input  logic [7:0]         byte_data,
   input  logic               word_valid,
   input  logic [47:0]        word_da,
   output logic               dec_valid,
   output logic               dec_accept,
   output logic               dec_group,
   output logic [IDX_W-1:0]   dec_index
);

   localparam int unsigned TBL_BITS = TABLE_REGS * REG_W;
   localparam int unsigned CNT_W    = $clog2(DA_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DA_BYTES - 1);

   // ---------------- configuration ----------------
   logic [TBL_BITS-1:0] tbl_live;
   logic [47:0]         stn_live;
   logic                prm_live;

   mhf_cfg_regs #(
      .TABLE_REGS (TABLE_REGS),
      .REG_W      (REG_W),
      .REG_AW     (REG_AW)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_addr   (cfg_wr_addr),
      .wr_data   (cfg_wr_data),
      .table_o   (tbl_live),
      .station_o (stn_live),
      .promisc_o (prm_live)
   );

   // ---------------- byte-stream collector ----------------
   rx_state_e            st_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [31:0]          crc_q;
   logic [DA_BITS-9:0]   da_q;
   logic [TBL_BITS-1:0]  tbl_snap;
   logic [47:0]          stn_snap;
   logic                 prm_snap;

   logic                 byte_take, b_start, b_cont, b_done;
   logic [31:0]          crc_seed, crc_b_next;
   logic [DA_BITS-1:0]   da_b_next;

   assign byte_take = byte_valid && !word_valid;
   assign b_start   = byte_take && byte_first;
   assign b_cont    = byte_take && !byte_first && (st_q == RX_OPEN);
   assign b_done    = b_cont && (cnt_q == LAST_CNT);
   assign crc_seed  = b_start ? CRC_PRESET : crc_q;
   assign da_b_next = {da_q, byte_data};

   mhf_crc_byte u_crc_stream (
      .crc_in  (crc_seed),
      .data_in (byte_data),
      .crc_out (crc_b_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RX_CLOSED;
         cnt_q <= '0;
         crc_q <= CRC_PRESET;
         da_q  <= '0;
      end else if (word_valid) begin
         st_q  <= RX_CLOSED;
         cnt_q <= '0;
      end else if (b_start) begin
         st_q  <= RX_OPEN;
         cnt_q <= CNT_W'(1);
         crc_q <= crc_b_next;
         da_q  <= da_b_next[DA_BITS-9:0];
      end else if (b_cont) begin
         cnt_q <= cnt_q + CNT_W'(1);
         crc_q <= crc_b_next;
         da_q  <= da_b_next[DA_BITS-9:0];
         if (b_done) st_q <= RX_CLOSED;
      end
   end

   // Configuration frozen for the frame that opens on this edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_snap <= '0;
         stn_snap <= '0;
         prm_snap <= 1'b0;
      end else if (b_start) begin
         tbl_snap <= tbl_live;
         stn_snap <= stn_live;
         prm_snap <= prm_live;
      end
   end

   // ---------------- whole-word CRC chain ----------------
   logic [31:0] wchain [DA_BYTES+1];
   assign wchain[0] = CRC_PRESET;

   for (genvar g = 0; g < DA_BYTES; g++) begin : g_wcrc
      mhf_crc_byte u_step (
         .crc_in  (wchain[g]),
         .data_in (word_da[DA_BITS-1-8*g -: 8]),
         .crc_out (wchain[g+1])
      );
   end

   logic unused_crc_hi;
   assign unused_crc_hi = ^{wchain[DA_BYTES][31:IDX_W], crc_b_next[31:IDX_W]};

   // ---------------- shared lookup ----------------
   logic [IDX_W-1:0]    lk_crc;
   logic [DA_BITS-1:0]  lk_da;
   logic [TBL_BITS-1:0] lk_tbl;
   logic [47:0]         lk_stn;
   logic                lk_prm;
   logic [IDX_W-1:0]    lk_index;
   logic                lk_group, lk_accept;

   assign lk_crc = word_valid ? wchain[DA_BYTES][IDX_W-1:0] : crc_b_next[IDX_W-1:0];
   assign lk_da  = word_valid ? word_da  : da_b_next;
   assign lk_tbl = word_valid ? tbl_live : tbl_snap;
   assign lk_stn = word_valid ? stn_live : stn_snap;
   assign lk_prm = word_valid ? prm_live : prm_snap;

   mhf_lookup #(
      .TABLE_REGS (TABLE_REGS),
      .REG_W      (REG_W)
   ) u_lookup (
      .crc_lo     (lk_crc),
      .da         (lk_da),
      .table_bits (lk_tbl),
      .station    (lk_stn),
      .promisc    (lk_prm),
      .index_o    (lk_index),
      .group_o    (lk_group),
      .accept_o   (lk_accept)
   );

   // ---------------- decision register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_group  <= 1'b0;
         dec_index  <= '0;
      end else begin
         dec_valid <= word_valid || b_done;
         if (word_valid || b_done) begin
            dec_accept <= lk_accept;
            dec_group  <= lk_group;
            dec_index  <= lk_index;
         end
      end
   end

   // R8: a word is always answered on the next cycle.
   a_r8_word_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> dec_valid);

   // R7: a decision only follows a word or a continuation byte.
   a_r7_decision_source: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> ($past(word_valid) || $past(byte_valid && !byte_first)));

   // R6: promiscuous mode accepts a word regardless of table or station.
   a_r6_promisc_word: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && prm_live) |=> dec_accept);

   // R4: group flag follows bit 0 of the first address byte.
   a_r4_group_word: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> (dec_group == $past(word_da[40])));

   // R9: unmarked bytes with no open frame never produce a decision.
   a_r9_closed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !byte_first && !word_valid && st_q == RX_CLOSED) |=> !dec_valid);

   // R9: the byte counter never passes the address length.
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DA_BYTES));

   // R11: a word in the same cycle as a byte closes the byte frame.
   a_r11_word_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && byte_valid) |=> (st_q == RX_CLOSED));

endmodule

// File: tb/mhf_filter_bench.sv
module mhf_filter_bench;

   localparam int CLK_PERIOD      = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [3:0]  cfg_wr_addr;
   logic [31:0] cfg_wr_data;
   logic        byte_valid, byte_first;
   logic [7:0]  byte_data;
   logic        word_valid;
   logic [47:0] word_da;
   logic        dec_valid, dec_accept, dec_group;
   logic [7:0]  dec_index;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mhf_filter u_mhf_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_wr_addr (cfg_wr_addr),
      .cfg_wr_data (cfg_wr_data),
      .byte_valid  (byte_valid),
      .byte_first  (byte_first),
      .byte_data   (byte_data),
      .word_valid  (word_valid),
      .word_da     (word_da),
      .dec_valid   (dec_valid),
      .dec_accept  (dec_accept),
      .dec_group   (dec_group),
      .dec_index   (dec_index)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_tbl [8];
   logic [47:0] m_stn;
   logic        m_prm;

   function automatic logic [7:0] ref_index(input logic [47:0] da);
      logic [31:0] c;
      logic [7:0]  b;
      logic [7:0]  idx;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         b = da[47-8*i -: 8];
         for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
         end
      end
      for (int j = 0; j < 8; j++) idx[7-j] = c[j];
      return idx;
   endfunction

   function automatic logic [9:0] ref_dec(input logic [47:0] da);
      logic [7:0] idx;
      logic       grp, acc;
      idx = ref_index(da);
      grp = da[40];
      if (m_prm)    acc = 1'b1;
      else if (grp) acc = m_tbl[idx[7:5]][31 - idx[4:0]];
      else          acc = (da == m_stn);
      return {acc, grp, idx};
   endfunction

   task automatic model_write(input logic [3:0] a, input logic [31:0] d);
      if (a < 4'd8)        m_tbl[a[2:0]] = d;
      else if (a == 4'd8)  m_stn[31:0]  = {d[7:0], d[15:8], d[23:16], d[31:24]};
      else if (a == 4'd9)  m_stn[47:32] = {d[23:16], d[31:24]};
      else if (a == 4'd10) m_prm = d[0];
   endtask

   // ---------------- checking helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_dec(input string tag, input logic [9:0] exp);
      chk({tag, " R7/R8 valid"}, {31'd0, dec_valid}, 32'd1);
      chk({tag, " R2/R5/R6 accept"}, {31'd0, dec_accept}, {31'd0, exp[9]});
      chk({tag, " R4 group"}, {31'd0, dec_group}, {31'd0, exp[8]});
      chk({tag, " R1 index"}, {24'd0, dec_index}, {24'd0, exp[7:0]});
   endtask

   task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic word_frame(input logic [47:0] da, input string tag);
      logic [9:0] exp;
      exp = ref_dec(da);
      @(negedge clk);
      word_valid = 1'b1; word_da = da;
      @(negedge clk);
      word_valid = 1'b0;
      check_dec(tag, exp);
   endtask

   task automatic byte_frame(input logic [47:0] da, input bit gaps, input bit mid_wr,
                             input logic [3:0] wa, input logic [31:0] wd, input string tag);
      logic [9:0] exp;
      int spur;
      int n;
      exp  = ref_dec(da);
      spur = 0;
      for (int i = 0; i < 6; i++) begin
         if (gaps && i > 0) begin
            n = $urandom % 3;
            repeat (n) begin
               @(negedge clk);
               if (dec_valid) spur++;
               byte_valid = 1'b0; cfg_wr_en = 1'b0;
            end
         end
         @(negedge clk);
         if (dec_valid) spur++;
         byte_valid = 1'b1; byte_first = (i == 0); byte_data = da[47-8*i -: 8];
         cfg_wr_en = mid_wr && (i == 2);
         if (mid_wr && i == 2) begin
            cfg_wr_addr = wa; cfg_wr_data = wd;
         end
      end
      @(negedge clk);
      byte_valid = 1'b0; byte_first = 1'b0; cfg_wr_en = 1'b0;
      if (mid_wr) model_write(wa, wd);
      check_dec(tag, exp);
      chk({tag, " R7 no early decision"}, spur, 0);
   endtask

   // Unmarked bytes: no decision may appear.
   task automatic loose_bytes(input int count, input string tag);
      int spur;
      spur = 0;
      for (int i = 0; i < count; i++) begin
         @(negedge clk);
         if (dec_valid) spur++;
         byte_valid = 1'b1; byte_first = 1'b0; byte_data = 8'($urandom);
      end
      @(negedge clk);
      if (dec_valid) spur++;
      byte_valid = 1'b0;
      @(negedge clk);
      if (dec_valid) spur++;
      chk(tag, spur, 0);
   endtask

   task automatic find_da(input logic [7:0] target, output logic [47:0] da);
      logic [47:0] c;
      da = 48'h0100_0000_0000;
      for (int t = 0; t < 200000; t++) begin
         c = {16'($urandom), 32'($urandom)};
         c[40] = 1'b1;
         if (ref_index(c) == target) begin
            da = c;
            break;
         end
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R7 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [47:0] da0, da1, da37, da254, da255, dstn, dx, dy;
      logic [9:0]  exp;
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0;
      cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
      byte_valid = 1'b0; byte_first = 1'b0; byte_data = '0;
      word_valid = 1'b0; word_da = '0;
      for (int k = 0; k < 8; k++) m_tbl[k] = '0;
      m_stn = '0; m_prm = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: reset state
      chk("R3 dec_valid after reset", {31'd0, dec_valid}, 32'd0);
      chk("R3 dec_accept after reset", {31'd0, dec_accept}, 32'd0);
      word_frame(48'hFFFF_FFFF_FFFF, "R3 broadcast");
      chk("R3 empty table rejects group", {31'd0, dec_accept}, 32'd0);
      word_frame(48'h0200_0000_0001, "R3 individual");
      chk("R3 promisc clear after reset", {31'd0, dec_accept}, 32'd0);

      // R9: unmarked bytes with no open frame
      loose_bytes(6, "R9 bytes without frame start");

      // R2: entry placement
      find_da(8'd0, da0);   find_da(8'd1, da1);   find_da(8'd37, da37);
      find_da(8'd254, da254); find_da(8'd255, da255);
      cfg_write(4'd0, 32'h8000_0000);
      word_frame(da0, "R2 entry 0");
      chk("R2 entry 0 is reg0 bit31", {31'd0, dec_accept}, 32'd1);
      word_frame(da1, "R2 entry 1");
      chk("R2 entry 1 clear", {31'd0, dec_accept}, 32'd0);
      cfg_write(4'd1, 32'h0400_0000);
      word_frame(da37, "R2 entry 37");
      chk("R2 entry 37 is reg1 bit26", {31'd0, dec_accept}, 32'd1);
      cfg_write(4'd7, 32'h0000_0001);
      word_frame(da255, "R2 entry 255");
      chk("R2 entry 255 is reg7 bit0", {31'd0, dec_accept}, 32'd1);
      word_frame(da254, "R2 entry 254");
      chk("R2 entry 254 clear", {31'd0, dec_accept}, 32'd0);

      // R5: station address match
      dstn = {16'($urandom), 32'($urandom)};
      dstn[40] = 1'b0;
      cfg_write(4'd8, {dstn[7:0], dstn[15:8], dstn[23:16], dstn[31:24]});
      cfg_write(4'd9, {dstn[39:32], dstn[47:40], 16'hBEEF});
      word_frame(dstn, "R5 station word");
      chk("R5 station match", {31'd0, dec_accept}, 32'd1);
      byte_frame(dstn, 1'b0, 1'b0, 4'd0, 32'd0, "R5 station bytes");
      dx = dstn ^ 48'h0000_0000_0080;
      word_frame(dx, "R5 one bit off");
      chk("R5 mismatch rejected", {31'd0, dec_accept}, 32'd0);

      // R6: promiscuous
      cfg_write(4'd10, 32'h0000_0001);
      word_frame(dx, "R6 promisc individual");
      chk("R6 promisc accepts", {31'd0, dec_accept}, 32'd1);
      byte_frame(da1, 1'b1, 1'b0, 4'd0, 32'd0, "R6 promisc group bytes");
      cfg_write(4'd10, 32'h0000_0000);

      // R7/R9: gaps, trailing bytes, restart
      byte_frame(da37, 1'b1, 1'b0, 4'd0, 32'd0, "R7 gapped frame");
      loose_bytes(3, "R9 bytes after sixth");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         byte_valid = 1'b1; byte_first = (i == 0); byte_data = 8'($urandom);
      end
      byte_frame(da255, 1'b0, 1'b0, 4'd0, 32'd0, "R9 restart mid frame");

      // R10: write during a frame affects only the next frame
      byte_frame(da0, 1'b0, 1'b1, 4'd0, 32'h0000_0000, "R10 old table kept");
      chk("R10 in-flight frame used old entry", {31'd0, dec_accept}, 32'd1);
      word_frame(da0, "R10 new table next");
      chk("R10 next frame sees cleared entry", {31'd0, dec_accept}, 32'd0);
      byte_frame(da1, 1'b1, 1'b1, 4'd0, 32'h4000_0000, "R10 old empty kept");
      chk("R10 in-flight frame ignored new entry", {31'd0, dec_accept}, 32'd0);
      byte_frame(da1, 1'b0, 1'b0, 4'd0, 32'd0, "R10 new entry next");
      chk("R10 next byte frame sees new entry", {31'd0, dec_accept}, 32'd1);

      // R11: word and byte collide
      dy = da255;
      exp = ref_dec(dy);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         byte_valid = 1'b1; byte_first = (i == 0); byte_data = da37[47-8*i -: 8];
      end
      @(negedge clk);
      byte_valid = 1'b1; byte_first = 1'b0; byte_data = da37[23:16];
      word_valid = 1'b1; word_da = dy;
      @(negedge clk);
      byte_valid = 1'b0; word_valid = 1'b0;
      check_dec("R11 word wins", exp);
      loose_bytes(2, "R11 abandoned frame gives no decision");

      // R12: unmapped writes
      for (int a = 11; a < 16; a++) cfg_write(4'(a), 32'hFFFF_FFFF);
      word_frame(da254, "R12 table untouched");
      chk("R12 entry 254 still clear", {31'd0, dec_accept}, 32'd0);
      word_frame(dx, "R12 promisc untouched");
      chk("R12 promisc still off", {31'd0, dec_accept}, 32'd0);

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int unsigned r, kind;
         logic [3:0]  a;
         logic [31:0] d;
         logic [47:0] da;
         r = $urandom % 10;
         if (r < 2) begin
            a = 4'($urandom % 13);
            d = $urandom;
            if (a == 4'd10) d[0] = (($urandom % 4) == 0);
            if (a < 4'd8 && ($urandom % 2) == 1) d = d & $urandom;
            cfg_write(a, d);
         end else begin
            kind = $urandom % 5;
            da = {16'($urandom), 32'($urandom)};
            if (kind < 2)       da[40] = 1'b1;
            else if (kind == 2) da = m_stn;
            else                da[40] = 1'b0;
            if (($urandom % 2) == 1) word_frame(da, "R1/R2/R5 random word");
            else byte_frame(da, ($urandom % 2) == 1, 1'b0, 4'd0, 32'd0, "R1/R2/R5 random bytes");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule